// File: doc/BRIEF.md
# MDIO Management Master

This block is a small management-bus master that carries one Clause 22 read or write to an external PHY per request. Software sets up the whole transaction in one 32-bit control word: direction, target register, write data, MDC divider choice, whether to skip the preamble, and a start flag. The 5-bit PHY address comes from a second configuration word. Once launched, the block derives MDC from its 25 MHz reference clock and shifts the frame out on MDIO. On a read it releases the line so the PHY can drive it.

Software polls the control word. The transaction is over when both the start flag and the busy flag read back as zero. After a read, the 16-bit result sits in the data field of the same word.

Top module: `mdio_master`

## Requirements
- R1: Control word layout is data [15:0], register address [20:16], read-not-write 21, skip-preamble 22, start 23, divider select [26:24], busy 27 (read-only, write value dropped), and [31:28] spare bits. The spare bits are stored and read back but do not change the frame. Reset clears both words. A word written with start at 0 is stored and launches nothing.
- R2: The PHY address field of the frame comes from bits [20:16] of the configuration word. That word reads back exactly as written.
- R3: After an accepted write with start at 1, start reads 1 and busy reads 0 in the next cycle. Busy reads 1 in the cycle after that and stays high for exactly (frame bits × divisor) cycles. Start and busy then fall together.
- R4: The frame is sent MSB first as: 32 ones (left out when skip-preamble is 1), 01, opcode (10 read, 01 write), PHY address, register address, two turnaround bits, 16 data bits. That is 64 bits with the preamble and 32 without. MDIO changes only while MDC is low.
- R5: On a write, turnaround is driven as 10 and the data bits come from the data field. MDIO is driven for every bit.
- R6: On a read, MDIO is released for the last 18 bits (turnaround and data). The PHY's bits are sampled while MDC is high, and the 16-bit result replaces the data field at completion.
- R7: Divider select 0..7 gives an MDC period of 4, 6, 8, 10, 14, 18, 22, 28 reference cycles. Each bit starts with MDC low for half the period, followed by MDC high for the other half.
- R8: Any write to the control word while start or busy is set is dropped, including one landing on the final busy cycle.
- R9: While idle, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst | input | 1 | synchronous active-high reset |
| ctrl_wr_en | input | 1 | write strobe for the control word |
| ctrl_wdata | input | 32 | control word write value |
| ctrl_rdata | output | 32 | control word readback with live busy |
| phycfg_wr_en | input | 1 | write strobe for the configuration word |
| phycfg_wdata | input | 32 | configuration word write value |
| phycfg_rdata | output | 32 | configuration word readback |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdc | output | 1 | management clock |

## Verification
Two events can fall in the same cycle: the end of a frame (start and busy clearing, read data landing in the word) and a new software write to the control word. The bench provokes this with a write in the last busy cycle. It then judges that the word holds the finished frame's result and that no new frame starts. A second injected write in the middle of a frame checks that the running transfer and its captured read data stay intact.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int CTRL_W    = 32;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int SEL_W     = 3;
    localparam int DIV_W     = 5;
    localparam int PRE_BITS  = 32;
    localparam int BODY_BITS = 32;
    localparam int FRAME_W   = PRE_BITS + BODY_BITS;
    localparam int IDX_W     = $clog2(FRAME_W);
    localparam int TA_BITS   = 2;
    localparam int PHY_LO    = 16;

    typedef struct packed {
        logic [3:0]        spare;
        logic              busy;
        logic [SEL_W-1:0]  sel;
        logic              start;
        logic              nopre;
        logic              rnw;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] data;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ARMED = 2'd1,
        ENG_SHIFT = 2'd2
    } eng_state_t;

    function automatic logic [DIV_W-1:0] mdc_divisor(input logic [SEL_W-1:0] sel);
        logic [DIV_W-1:0] d;
        case (sel)
            3'd0:    d = 5'd4;
            3'd1:    d = 5'd6;
            3'd2:    d = 5'd8;
            3'd3:    d = 5'd10;
            3'd4:    d = 5'd14;
            3'd5:    d = 5'd18;
            3'd6:    d = 5'd22;
            default: d = 5'd28;
        endcase
        return d;
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input ctrl_word_t c,
                                                      input logic [ADDR_W-1:0] phy);
        logic [1:0] op;
        op = c.rnw ? 2'b10 : 2'b01;
        return {{PRE_BITS{1'b1}}, 2'b01, op, phy, c.regad, 2'b10, c.data};
    endfunction

    function automatic logic [IDX_W-1:0] first_index(input logic nopre);
        return nopre ? IDX_W'(BODY_BITS - 1) : IDX_W'(FRAME_W - 1);
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             sample_stb,
    output logic             bit_end
);
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;

    assign div  = mdc_divisor(sel);
    assign half = div >> 1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == div - 1'b1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign mdc        = run && (cnt >= half);
    assign sample_stb = run && (cnt == half);
    assign bit_end    = run && (cnt == div - 1'b1);

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < div));

    assert_low_first_R7: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) && $past(bit_end) |-> !mdc);

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               active,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [IDX_W-1:0]   first_idx,
    input  logic               rnw_in,
    input  logic               sample_stb,
    input  logic               bit_end,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               last_bit,
    output logic [DATA_W-1:0]  rx_data
);
    localparam logic [IDX_W-1:0] RELEASE_IDX = IDX_W'(DATA_W + TA_BITS - 1);
    localparam logic [IDX_W-1:0] DATA_TOP    = IDX_W'(DATA_W - 1);

    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   idx_q;
    logic               rnw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            idx_q   <= '0;
            rnw_q   <= 1'b0;
            rx_data <= '0;
        end else if (load) begin
            frame_q <= frame_in;
            idx_q   <= first_idx;
            rnw_q   <= rnw_in;
            rx_data <= '0;
        end else if (active) begin
            if (sample_stb && rnw_q && (idx_q <= DATA_TOP)) begin
                rx_data <= {rx_data[DATA_W-2:0], mdio_i};
            end
            if (bit_end && (idx_q != '0)) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    assign last_bit = (idx_q == '0);
    assign mdio_oe  = active && !(rnw_q && (idx_q <= RELEASE_IDX));
    assign mdio_o   = mdio_oe && frame_q[idx_q];

    assert_idx_moves_on_bit_end_R4: assert property (@(posedge clk) disable iff (rst)
        active && !load && !bit_end |=> $stable(idx_q));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr_en,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              phycfg_wr_en,
    input  logic [CTRL_W-1:0] phycfg_wdata,
    output logic [CTRL_W-1:0] phycfg_rdata,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              mdc
);
    eng_state_t         state_q;
    ctrl_word_t         ctrl_q;
    ctrl_word_t         wr_word;
    logic [CTRL_W-1:0]  phycfg_q;
    logic               busy;
    logic               load;
    logic               sample_stb;
    logic               bit_end;
    logic               last_bit;
    logic [DATA_W-1:0]  rx_data;
    logic [ADDR_W-1:0]  phy_addr;
    logic [FRAME_W-1:0] frame;

    assign wr_word  = ctrl_word_t'(ctrl_wdata);
    assign busy     = (state_q == ENG_SHIFT);
    assign load     = (state_q == ENG_ARMED);
    assign phy_addr = phycfg_q[PHY_LO +: ADDR_W];
    assign frame    = build_frame(ctrl_q, phy_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ENG_IDLE;
            ctrl_q   <= '0;
            phycfg_q <= '0;
        end else begin
            if (phycfg_wr_en) begin
                phycfg_q <= phycfg_wdata;
            end
            case (state_q)
                ENG_IDLE: begin
                    if (ctrl_wr_en) begin
                        ctrl_q      <= wr_word;
                        ctrl_q.busy <= 1'b0;
                        if (wr_word.start) begin
                            state_q <= ENG_ARMED;
                        end
                    end
                end
                ENG_ARMED: begin
                    state_q <= ENG_SHIFT;
                end
                ENG_SHIFT: begin
                    if (bit_end && last_bit) begin
                        state_q      <= ENG_IDLE;
                        ctrl_q.start <= 1'b0;
                        if (ctrl_q.rnw) begin
                            ctrl_q.data <= rx_data;
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        ctrl_word_t rd;
        rd         = ctrl_q;
        rd.busy    = busy;
        ctrl_rdata = CTRL_W'(rd);
    end
    assign phycfg_rdata = phycfg_q;

    mdio_clkgen u_clkgen (
        .clk        (clk),
        .rst        (rst),
        .run        (busy),
        .sel        (ctrl_q.sel),
        .mdc        (mdc),
        .sample_stb (sample_stb),
        .bit_end    (bit_end)
    );

    mdio_shifter u_shifter (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .active     (busy),
        .frame_in   (frame),
        .first_idx  (first_index(ctrl_q.nopre)),
        .rnw_in     (ctrl_q.rnw),
        .sample_stb (sample_stb),
        .bit_end    (bit_end),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .last_bit   (last_bit),
        .rx_data    (rx_data)
    );

    assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctrl_q.start));

    assert_start_clears_with_busy_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.start) |-> $fell(busy));

    assert_busy_implies_start_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> ctrl_q.start);

    assert_mdio_moves_low_R4: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && !$stable(mdio_o) |-> !mdc);

    assert_release_only_on_read_R6: assert property (@(posedge clk) disable iff (rst)
        busy && $fell(mdio_oe) |-> ctrl_q.rnw);

    assert_ignore_busy_write_R8: assert property (@(posedge clk) disable iff (rst)
        busy && ctrl_wr_en |=> $stable(ctrl_q.regad) && $stable(ctrl_q.sel)
                               && $stable(ctrl_q.spare) && $stable(ctrl_q.rnw));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe && !mdc);

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam time CLK_PERIOD = 40ns;
    localparam int  WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr_en = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        phycfg_wr_en = 1'b0;
    logic [31:0] phycfg_wdata = '0;
    logic [31:0] phycfg_rdata;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdc;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic cap_bit [0:63];
    logic cap_oe  [0:63];
    int   ncap = 0;
    int   last_rise = 0;
    bit   have_rise = 0;
    int   per_min = 0;
    int   per_max = 0;
    bit   rd_mode = 0;
    int   cur_len = 64;
    logic [15:0] rd_val = '0;

    mdio_master u_mdio_master (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr_en   (ctrl_wr_en),
        .ctrl_wdata   (ctrl_wdata),
        .ctrl_rdata   (ctrl_rdata),
        .phycfg_wr_en (phycfg_wr_en),
        .phycfg_wdata (phycfg_wdata),
        .phycfg_rdata (phycfg_rdata),
        .mdio_i       (mdio_i),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe),
        .mdc          (mdc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // PHY model: record each rising MDC edge
    always @(posedge mdc) begin
        if (ncap < 64) begin
            cap_bit[ncap] = mdio_o;
            cap_oe[ncap]  = mdio_oe;
        end
        ncap = ncap + 1;
        if (have_rise) begin
            if (cyc - last_rise < per_min) per_min = cyc - last_rise;
            if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        have_rise = 1;
        last_rise = cyc;
    end

    // PHY model: drive read data while MDC is low
    always @(negedge mdc) begin
        if (rd_mode && ncap >= cur_len - 16 && ncap < cur_len)
            mdio_i = rd_val[cur_len - 1 - ncap];
        else
            mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_div(input logic [2:0] sel);
        int t [0:7] = '{4, 6, 8, 10, 14, 18, 22, 28};
        return t[sel];
    endfunction

    task automatic write_phycfg(input logic [31:0] v);
        @(negedge clk);
        phycfg_wr_en = 1'b1;
        phycfg_wdata = v;
        @(negedge clk);
        phycfg_wr_en = 1'b0;
        chk(phycfg_rdata == v, "R2", "config readback", phycfg_rdata, v);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(ctrl_rdata == 32'h0, "R1", "control word after reset", ctrl_rdata, 0);
        chk(phycfg_rdata == 32'h0, "R2", "config word after reset", phycfg_rdata, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9", "idle mdc/oe", {mdc, mdio_oe}, 0);
    endtask

    task automatic test_no_start(input logic [31:0] word);
        @(negedge clk);
        ctrl_wr_en = 1'b1;
        ctrl_wdata = word;
        @(negedge clk);
        ctrl_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(ctrl_rdata == (word & 32'hF7FF_FFFF), "R1", "word stored without start",
            ctrl_rdata, word & 32'hF7FF_FFFF);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9", "no launch without start", {mdc, mdio_oe}, 0);
    endtask

    task automatic run_frame(input logic [31:0] word, input logic [4:0] phy,
                             input logic [15:0] phy_rd, input int inject_at,
                             input logic [31:0] inj_word, input string tag);
        int len;
        int dv;
        int n;
        int bad;
        int first_bad;
        logic [63:0] ef;
        logic [31:0] exp_word;
        bit rnw;
        len = word[22] ? 32 : 64;
        dv  = exp_div(word[26:24]);
        rnw = word[21];
        ef  = {32'hFFFF_FFFF, 2'b01, (rnw ? 2'b10 : 2'b01), phy, word[20:16], 2'b10, word[15:0]};
        ncap = 0; have_rise = 0; per_min = 1000; per_max = 0;
        rd_mode = rnw; cur_len = len; rd_val = phy_rd;

        @(negedge clk);
        ctrl_wr_en = 1'b1;
        ctrl_wdata = word;
        @(negedge clk);
        ctrl_wr_en = 1'b0;
        chk(ctrl_rdata[23] == 1'b1 && ctrl_rdata[27] == 1'b0, "R3",
            {tag, " start set, busy not yet"}, ctrl_rdata[27:23], 5'h01);
        @(negedge clk);
        chk(ctrl_rdata[27] == 1'b1, "R3", {tag, " busy one cycle later"}, ctrl_rdata[27], 1);
        n = 1;
        while (ctrl_rdata[27] && n < 5000) begin
            if (n == inject_at) begin
                ctrl_wr_en = 1'b1;
                ctrl_wdata = inj_word;
            end else begin
                ctrl_wr_en = 1'b0;
            end
            @(negedge clk);
            if (ctrl_rdata[27]) n = n + 1;
        end
        ctrl_wr_en = 1'b0;
        chk(n == len * dv, "R3", {tag, " busy cycle count"}, n, len * dv);
        chk(ctrl_rdata[23] == 1'b0, "R3", {tag, " start cleared with busy"}, ctrl_rdata[23], 0);
        if (inject_at > 0) begin
            repeat (2) @(negedge clk);
            chk(ctrl_rdata[27] == 1'b0 && ctrl_rdata[23] == 1'b0, "R8",
                {tag, " injected write launched nothing"}, ctrl_rdata[27:23], 0);
        end

        chk(ncap == len, "R4", {tag, " MDC rising edges"}, ncap, len);
        bad = 0; first_bad = -1;
        for (int p = 0; p < len && p < 64; p++) begin
            bit eoe;
            eoe = !(rnw && p >= len - 18);
            if (cap_oe[p] !== eoe || (eoe && cap_bit[p] !== ef[len - 1 - p])) begin
                bad = bad + 1;
                if (first_bad < 0) first_bad = p;
            end
        end
        chk(bad == 0, rnw ? "R6" : "R5", {tag, " frame bits/enable (first bad position)"},
            first_bad, -1);
        chk(per_min == dv && per_max == dv, "R7", {tag, " MDC period"},
            {per_min[31:0], per_max[31:0]}, {dv[31:0], dv[31:0]});

        exp_word = word;
        exp_word[27] = 1'b0;
        exp_word[23] = 1'b0;
        if (rnw) exp_word[15:0] = phy_rd;
        chk(ctrl_rdata == exp_word, rnw ? "R6" : "R1", {tag, " final control word"},
            ctrl_rdata, exp_word);
        rd_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();

        // R2: PHY address 0x13 in [20:16], other bits carry junk
        write_phycfg(32'hC013_5A5A);
        // R5/R1: write, preamble, sel 0, spare bits A and busy bit set in written value
        run_frame({4'hA, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 5'h0A, 16'hA5C3}, 5'h13,
                  16'h0, 0, 32'h0, "write sel0");

        // R6: read without preamble at the slowest divider
        write_phycfg(32'h0001_0000);
        run_frame({4'h0, 1'b0, 3'd7, 1'b1, 1'b1, 1'b1, 5'h1F, 16'h0000}, 5'h01,
                  16'h6E29, 0, 32'h0, "read sel7 nopre");

        // R8: read with preamble, write injected mid-frame
        write_phycfg(32'h001C_0000);
        run_frame({4'h3, 1'b0, 3'd3, 1'b1, 1'b0, 1'b1, 5'h05, 16'hFFFF}, 5'h1C,
                  16'h813C, 50, {4'h5, 1'b0, 3'd1, 1'b1, 1'b1, 1'b0, 5'h11, 16'h1234},
                  "read sel3 injected");

        // R8: write landing on the last busy cycle
        run_frame({4'h0, 1'b0, 3'd5, 1'b1, 1'b1, 1'b0, 5'h02, 16'h0F0F}, 5'h1C,
                  16'h0, 576, {4'h6, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 5'h07, 16'h4321},
                  "write sel5 collision");

        // R1: word without start is kept but launches nothing
        test_no_start({4'h9, 1'b1, 3'd4, 1'b0, 1'b1, 1'b0, 5'h15, 16'hBEEF});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule